// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block runs the byte-level side of an I2C master. A command port loads a target address (7-bit or 10-bit), a direction, a byte count and a reload bit, then fires a start strobe. The sequencer produces START, the address phase, the data bytes and the acknowledge slots. It exchanges data with software through a transmit holding port and a receive holding register. Every single bus bit is handed to an external SCL timing generator. That generator acknowledges each bit and returns the SDA level it sampled.

The transfer is cut into chunks by a byte counter. When a chunk ends, the sequencer stalls the bus with SCL held low. It then waits for one of three commands: a new count (reload), a STOP, or a repeated START. A NACK from the target closes the transfer with an automatic STOP. Bus errors and lost arbitration abort the transfer at once. Each event leaves a sticky flag that software clears by writing a one.

Top module: `i2cm_xfer_seq`

## Requirements
- R1: After reset, every status flag, `st_busy`, `bit_req`, `scl_hold` and every field readback (`fld_*`) is zero.
- R2: Bits go to the timing generator one at a time. `bit_req` stays high with a stable `bit_op` until `bit_done`. The op codes are 0 START, 1 STOP, 2 WRITE (drive `bit_tx`) and 3 READ (release SDA and sample `bit_rx`). In 7-bit mode the address byte is `cmd_addr[7:1]` followed by the direction bit (1 = read), sent MSB first, and `cmd_addr[9:8]` are ignored.
- R3: In 10-bit mode the sequencer sends the header `11110,a9,a8,0` and then `a[7:0]`. For a read it then sends a repeated START and the header `11110,a9,a8,1`.
- R4: In a write, `st_txis` rises when the next byte is needed and the bus stalls. A `tx_wr` clears it. Data goes out MSB first, and each byte is followed by a READ acknowledge slot.
- R5: In a read, `st_rxne` rises once a received byte is in `rx_data`, and an `rx_rd` pulse clears it. After each byte the master drives ACK (0). The only exception is the last byte of a chunk without reload, which gets NACK (1).
- R6: When the count reaches zero and reload is clear, `st_tc` rises. The bus then stalls with no bit request until a `cmd_stop` (which issues STOP) or a `cmd_start`.
- R7: When the count reaches zero and reload is set, `st_tcr` rises and the bus stalls. A `cmd_count_wr` loads the new count and reload bit and continues the transfer with no START or STOP.
- R8: A 1 sampled in any acknowledge slot after a written byte (address or data) sets `st_nack`. STOP then follows automatically, and `st_stopf` is set.
- R9: If a WRITE bit of 1 samples 0 during an address or data byte, `st_arlo` is set. The sequencer drops its bit request, leaves busy and issues no STOP.
- R10: A `bus_err` pulse sets `st_berr` and aborts any transfer in progress to idle, with busy cleared.
- R11: `st_busy` goes high when START completes and low when STOP completes. A `cmd_start` is ignored while busy, except in the transfer-complete wait.
- R12: When STOP completes, the address, 10-bit flag, direction, count and reload readbacks return to zero.
- R13: Status flags are sticky. `flag_clr` bit 0 clears `st_stopf`, bit 1 clears `st_nack`, bit 2 clears `st_berr` and bit 3 clears `st_arlo`. A clear bit affects only its own flag.
- R14: A `cmd_start` in the transfer-complete wait issues a repeated START with the new fields, and no STOP comes before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_start | input | 1 | Load fields and generate START / repeated START |
| cmd_addr | input | 10 | Target address field |
| cmd_ten | input | 1 | 1 selects 10-bit addressing |
| cmd_rd | input | 1 | Direction, 1 = read from target |
| cmd_nbytes | input | 8 | Byte count of the chunk |
| cmd_reload | input | 1 | Reload mode for the chunk |
| cmd_stop | input | 1 | Generate STOP from the transfer-complete wait |
| cmd_count_wr | input | 1 | Load new count and reload bit from the reload wait |
| tx_wr | input | 1 | Write transmit holding byte |
| tx_data | input | 8 | Transmit byte |
| rx_rd | input | 1 | Read strobe for the receive register |
| rx_data | output | 8 | Receive holding register |
| flag_clr | input | 4 | Write-one-to-clear vector (stop, nack, berr, arlo) |
| st_txis | output | 1 | Transmit byte requested |
| st_rxne | output | 1 | Receive byte waiting |
| st_tc | output | 1 | Chunk complete, no reload |
| st_tcr | output | 1 | Chunk complete, reload pending |
| st_busy | output | 1 | Bus owned between START and STOP |
| st_stopf | output | 1 | STOP completed |
| st_nack | output | 1 | NACK received |
| st_berr | output | 1 | Bus error |
| st_arlo | output | 1 | Arbitration lost |
| fld_addr | output | 10 | Address field readback |
| fld_ten | output | 1 | 10-bit flag readback |
| fld_rd | output | 1 | Direction readback |
| fld_count | output | 8 | Remaining byte count |
| fld_reload | output | 1 | Reload bit readback |
| scl_hold | output | 1 | Sequencer stalls the bus with SCL low |
| bit_req | output | 1 | Bit operation request |
| bit_op | output | 2 | Bit operation code |
| bit_tx | output | 1 | Level to drive on WRITE |
| bit_done | input | 1 | Bit operation finished |
| bit_rx | input | 1 | SDA level sampled for the bit |
| bus_err | input | 1 | Misplaced START/STOP detected on the bus |

## Verification
The main path is tried with 7-bit writes and reads of one and several bytes, a 7-bit write whose upper address bits are set, 10-bit writes and reads, and a zero-byte transfer. Comparing the logged bus bits tells a wrong address layout from a wrong header, a missing repeated START, wrong acknowledge polarity, and bit-order faults. Directed runs then separate reload chunking (ACK on the last byte of a chunk, no extra START/STOP) from plain completion and repeated START. They also drive the three abort paths, showing that a NACK ends in STOP while arbitration loss and bus error do not. The flag clears are exercised one at a time.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } bit_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_ADDR,
        S_ADDR_ACK,
        S_DATA_CHK,
        S_TX_WAIT,
        S_TX_BITS,
        S_TX_ACK,
        S_RX_BITS,
        S_RX_HOLD,
        S_RX_ACK,
        S_WAIT_TC,
        S_WAIT_TCR,
        S_STOP
    } seq_state_e;

    localparam int FLAG_STOP = 0;
    localparam int FLAG_NACK = 1;
    localparam int FLAG_BERR = 2;
    localparam int FLAG_ARLO = 3;
    localparam int NUM_FLAGS = 4;

    localparam logic [4:0] HDR10_TAG = 5'b11110;

endpackage

// File: rtl/i2cm_shifter.sv
module i2cm_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         shift_in,
    output logic [W-1:0] byte_q,
    output logic         msb,
    output logic         last
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic [W-1:0]  sr;
        logic [CW-1:0] cnt;
    } shf_t;

    shf_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.sr  = load_val;
            sh_d.cnt = '0;
        end else if (shift) begin
            sh_d.sr  = {sh_q.sr[W-2:0], shift_in};
            sh_d.cnt = sh_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign byte_q = sh_q.sr;
    assign msb    = sh_q.sr[W-1];
    assign last   = (sh_q.cnt == CW'(W - 1));

endmodule

// File: rtl/i2cm_flags.sv
module i2cm_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flg_d, flg_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        // a new event wins over a clear in the same cycle
        always_comb begin
            if (set_i[i])      flg_d[i] = 1'b1;
            else if (clr_i[i]) flg_d[i] = 1'b0;
            else               flg_d[i] = flg_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign flag_o = flg_q;

endmodule

// File: rtl/i2cm_seq_fsm.sv
module i2cm_seq_fsm
    import i2cm_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_ten,
    input  logic              cmd_rd,
    input  logic [CNT_W-1:0]  cmd_nbytes,
    input  logic              cmd_reload,
    input  logic              cmd_stop,
    input  logic              cmd_count_wr,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    input  logic              bit_done,
    input  logic              bit_rx,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] sh_byte,
    input  logic              sh_msb,
    input  logic              sh_last,
    output logic              sh_load,
    output logic [DATA_W-1:0] sh_load_val,
    output logic              sh_shift,
    output logic              sh_in,
    output logic              bit_req,
    output logic [1:0]        bit_op,
    output logic              bit_tx,
    output logic [NUM_FLAGS-1:0] flag_set,
    output logic [DATA_W-1:0] rx_data,
    output logic              st_txis,
    output logic              st_rxne,
    output logic              st_tc,
    output logic              st_tcr,
    output logic              st_busy,
    output logic              scl_hold,
    output logic [ADDR_W-1:0] fld_addr,
    output logic              fld_ten,
    output logic              fld_rd,
    output logic [CNT_W-1:0]  fld_count,
    output logic              fld_reload
);
    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              ten;
        logic              rd;
        logic              rel;
        logic [1:0]        astep;
        logic [DATA_W-1:0] rxd;
        logic              rxne;
        logic              busy;
    } seq_t;

    seq_t seq_d, seq_q;

    // address byte for the first header (step 0) or the read header (step 2)
    function automatic logic [DATA_W-1:0] addr_byte(input seq_t s);
        logic [DATA_W-1:0] b;
        if (s.astep == 2'd2)
            b = {HDR10_TAG, s.addr[9:8], 1'b1};
        else if (s.ten)
            b = {HDR10_TAG, s.addr[9:8], 1'b0};
        else
            b = {s.addr[7:1], s.rd};
        return b;
    endfunction

    always_comb begin
        seq_d       = seq_q;
        sh_load     = 1'b0;
        sh_load_val = '0;
        sh_shift    = 1'b0;
        sh_in       = 1'b0;
        flag_set    = '0;

        if (rx_rd) seq_d.rxne = 1'b0;

        case (seq_q.st)
            S_IDLE: begin
                if (cmd_start) begin
                    seq_d.addr  = cmd_addr;
                    seq_d.ten   = cmd_ten;
                    seq_d.rd    = cmd_rd;
                    seq_d.cnt   = cmd_nbytes;
                    seq_d.rel   = cmd_reload;
                    seq_d.astep = 2'd0;
                    seq_d.st    = S_START;
                end
            end
            S_START: begin
                if (bit_done) begin
                    seq_d.busy  = 1'b1;
                    sh_load     = 1'b1;
                    sh_load_val = addr_byte(seq_q);
                    seq_d.st    = S_ADDR;
                end
            end
            S_ADDR, S_TX_BITS: begin
                if (bit_done) begin
                    if (sh_msb && !bit_rx) begin
                        flag_set[FLAG_ARLO] = 1'b1;
                        seq_d.busy          = 1'b0;
                        seq_d.st            = S_IDLE;
                    end else begin
                        sh_shift = 1'b1;
                        sh_in    = bit_rx;
                        if (sh_last)
                            seq_d.st = (seq_q.st == S_ADDR) ? S_ADDR_ACK : S_TX_ACK;
                    end
                end
            end
            S_ADDR_ACK: begin
                if (bit_done) begin
                    if (bit_rx) begin
                        flag_set[FLAG_NACK] = 1'b1;
                        seq_d.st            = S_STOP;
                    end else if (seq_q.ten && seq_q.astep == 2'd0) begin
                        seq_d.astep = 2'd1;
                        sh_load     = 1'b1;
                        sh_load_val = seq_q.addr[DATA_W-1:0];
                        seq_d.st    = S_ADDR;
                    end else if (seq_q.ten && seq_q.astep == 2'd1 && seq_q.rd) begin
                        seq_d.astep = 2'd2;
                        seq_d.st    = S_START;
                    end else begin
                        seq_d.st = S_DATA_CHK;
                    end
                end
            end
            S_DATA_CHK: begin
                if (seq_q.cnt == '0)
                    seq_d.st = seq_q.rel ? S_WAIT_TCR : S_WAIT_TC;
                else if (seq_q.rd) begin
                    sh_load  = 1'b1;
                    seq_d.st = S_RX_BITS;
                end else
                    seq_d.st = S_TX_WAIT;
            end
            S_TX_WAIT: begin
                if (tx_wr) begin
                    sh_load     = 1'b1;
                    sh_load_val = tx_data;
                    seq_d.st    = S_TX_BITS;
                end
            end
            S_TX_ACK: begin
                if (bit_done) begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                    if (bit_rx) begin
                        flag_set[FLAG_NACK] = 1'b1;
                        seq_d.st            = S_STOP;
                    end else
                        seq_d.st = S_DATA_CHK;
                end
            end
            S_RX_BITS: begin
                if (bit_done) begin
                    sh_shift = 1'b1;
                    sh_in    = bit_rx;
                    if (sh_last) seq_d.st = S_RX_HOLD;
                end
            end
            S_RX_HOLD: begin
                if (!seq_q.rxne) begin
                    seq_d.rxd  = sh_byte;
                    seq_d.rxne = 1'b1;
                    seq_d.cnt  = seq_q.cnt - 1'b1;
                    seq_d.st   = S_RX_ACK;
                end
            end
            S_RX_ACK: begin
                if (bit_done) seq_d.st = S_DATA_CHK;
            end
            S_WAIT_TC: begin
                if (cmd_start) begin
                    seq_d.addr  = cmd_addr;
                    seq_d.ten   = cmd_ten;
                    seq_d.rd    = cmd_rd;
                    seq_d.cnt   = cmd_nbytes;
                    seq_d.rel   = cmd_reload;
                    seq_d.astep = 2'd0;
                    seq_d.st    = S_START;
                end else if (cmd_stop) begin
                    seq_d.st = S_STOP;
                end
            end
            S_WAIT_TCR: begin
                if (cmd_count_wr) begin
                    seq_d.cnt = cmd_nbytes;
                    seq_d.rel = cmd_reload;
                    seq_d.st  = S_DATA_CHK;
                end
            end
            S_STOP: begin
                if (bit_done) begin
                    flag_set[FLAG_STOP] = 1'b1;
                    seq_d.busy  = 1'b0;
                    seq_d.cnt   = '0;
                    seq_d.addr  = '0;
                    seq_d.ten   = 1'b0;
                    seq_d.rd    = 1'b0;
                    seq_d.rel   = 1'b0;
                    seq_d.astep = 2'd0;
                    seq_d.st    = S_IDLE;
                end
            end
            default: seq_d.st = S_IDLE;
        endcase

        // a misplaced bus condition overrides whatever the sequence was doing
        if (bus_err) begin
            flag_set[FLAG_BERR] = 1'b1;
            if (seq_q.st != S_IDLE) begin
                seq_d.st   = S_IDLE;
                seq_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: S_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    // bit request decode
    always_comb begin
        bit_req = 1'b1;
        bit_op  = OP_READ;
        bit_tx  = 1'b1;
        case (seq_q.st)
            S_START:              bit_op = OP_START;
            S_STOP:               bit_op = OP_STOP;
            S_ADDR, S_TX_BITS: begin
                bit_op = OP_WRITE;
                bit_tx = sh_msb;
            end
            S_RX_ACK: begin
                bit_op = OP_WRITE;
                bit_tx = (seq_q.cnt == '0) && !seq_q.rel;
            end
            S_ADDR_ACK, S_TX_ACK, S_RX_BITS: bit_op = OP_READ;
            default:              bit_req = 1'b0;
        endcase
    end

    assign rx_data    = seq_q.rxd;
    assign st_rxne    = seq_q.rxne;
    assign st_busy    = seq_q.busy;
    assign st_txis    = (seq_q.st == S_TX_WAIT);
    assign st_tc      = (seq_q.st == S_WAIT_TC);
    assign st_tcr     = (seq_q.st == S_WAIT_TCR);
    assign scl_hold   = (seq_q.st == S_TX_WAIT) || (seq_q.st == S_RX_HOLD) ||
                        (seq_q.st == S_WAIT_TC) || (seq_q.st == S_WAIT_TCR);
    assign fld_addr   = seq_q.addr;
    assign fld_ten    = seq_q.ten;
    assign fld_rd     = seq_q.rd;
    assign fld_count  = seq_q.cnt;
    assign fld_reload = seq_q.rel;

endmodule

// File: rtl/i2cm_xfer_seq.sv
module i2cm_xfer_seq
    import i2cm_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_ten,
    input  logic              cmd_rd,
    input  logic [CNT_W-1:0]  cmd_nbytes,
    input  logic              cmd_reload,
    input  logic              cmd_stop,
    input  logic              cmd_count_wr,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    input  logic [3:0]        flag_clr,
    output logic              st_txis,
    output logic              st_rxne,
    output logic              st_tc,
    output logic              st_tcr,
    output logic              st_busy,
    output logic              st_stopf,
    output logic              st_nack,
    output logic              st_berr,
    output logic              st_arlo,
    output logic [ADDR_W-1:0] fld_addr,
    output logic              fld_ten,
    output logic              fld_rd,
    output logic [CNT_W-1:0]  fld_count,
    output logic              fld_reload,
    output logic              scl_hold,
    output logic              bit_req,
    output logic [1:0]        bit_op,
    output logic              bit_tx,
    input  logic              bit_done,
    input  logic              bit_rx,
    input  logic              bus_err
);
    logic [DATA_W-1:0]    sh_byte, sh_load_val;
    logic                 sh_msb, sh_last, sh_load, sh_shift, sh_in;
    logic [NUM_FLAGS-1:0] flag_set, flag_q;

    i2cm_seq_fsm #(
        .CNT_W (CNT_W),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_start   (cmd_start),
        .cmd_addr    (cmd_addr),
        .cmd_ten     (cmd_ten),
        .cmd_rd      (cmd_rd),
        .cmd_nbytes  (cmd_nbytes),
        .cmd_reload  (cmd_reload),
        .cmd_stop    (cmd_stop),
        .cmd_count_wr(cmd_count_wr),
        .tx_wr       (tx_wr),
        .tx_data     (tx_data),
        .rx_rd       (rx_rd),
        .bit_done    (bit_done),
        .bit_rx      (bit_rx),
        .bus_err     (bus_err),
        .sh_byte     (sh_byte),
        .sh_msb      (sh_msb),
        .sh_last     (sh_last),
        .sh_load     (sh_load),
        .sh_load_val (sh_load_val),
        .sh_shift    (sh_shift),
        .sh_in       (sh_in),
        .bit_req     (bit_req),
        .bit_op      (bit_op),
        .bit_tx      (bit_tx),
        .flag_set    (flag_set),
        .rx_data     (rx_data),
        .st_txis     (st_txis),
        .st_rxne     (st_rxne),
        .st_tc       (st_tc),
        .st_tcr      (st_tcr),
        .st_busy     (st_busy),
        .scl_hold    (scl_hold),
        .fld_addr    (fld_addr),
        .fld_ten     (fld_ten),
        .fld_rd      (fld_rd),
        .fld_count   (fld_count),
        .fld_reload  (fld_reload)
    );

    i2cm_shifter #(.W(DATA_W)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .load_val(sh_load_val),
        .shift   (sh_shift),
        .shift_in(sh_in),
        .byte_q  (sh_byte),
        .msb     (sh_msb),
        .last    (sh_last)
    );

    i2cm_flags #(.N(NUM_FLAGS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (flag_set),
        .clr_i (flag_clr),
        .flag_o(flag_q)
    );

    assign st_stopf = flag_q[FLAG_STOP];
    assign st_nack  = flag_q[FLAG_NACK];
    assign st_berr  = flag_q[FLAG_BERR];
    assign st_arlo  = flag_q[FLAG_ARLO];

endmodule

// File: rtl/i2cm_xfer_seq_chk.sv
module i2cm_xfer_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_rd,
    input logic [3:0] flag_clr,
    input logic       st_txis,
    input logic       st_rxne,
    input logic       st_tc,
    input logic       st_tcr,
    input logic       st_busy,
    input logic       st_stopf,
    input logic       st_nack,
    input logic       st_arlo,
    input logic [9:0] fld_addr,
    input logic       fld_ten,
    input logic       fld_rd,
    input logic [7:0] fld_count,
    input logic       fld_reload,
    input logic       scl_hold,
    input logic       bit_req,
    input logic [1:0] bit_op,
    input logic       bit_done,
    input logic       bus_err
);
    // R2
    handshake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_req && !bit_done && !bus_err |=> bit_req && $stable(bit_op));

    // R4
    txis_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_txis |-> st_busy && !bit_req && scl_hold);

    // R5
    rxne_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_rxne && !rx_rd |=> st_rxne);

    // R6
    tc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_tc |-> !bit_req && scl_hold);

    // R7
    tcr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_tcr |-> !bit_req && scl_hold);

    // R9
    arlo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_arlo) |-> !bit_req && !st_busy);

    // R11
    stop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_req && bit_done && bit_op == 2'd1 && !bus_err |=> !st_busy && st_stopf);

    // R12
    stop_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_req && bit_done && bit_op == 2'd1 && !bus_err |=>
        fld_count == 8'd0 && fld_addr == 10'd0 && !fld_rd && !fld_ten && !fld_reload);

    // R13
    nack_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_nack && !flag_clr[1] |=> st_nack);

endmodule

bind i2cm_xfer_seq i2cm_xfer_seq_chk u_chk (.*);

// File: tb/i2cm_xfer_seq_tb.sv
module i2cm_xfer_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_start = 0, cmd_ten = 0, cmd_rd = 0, cmd_reload = 0;
    logic       cmd_stop = 0, cmd_count_wr = 0, tx_wr = 0, rx_rd = 0, bus_err = 0;
    logic [9:0] cmd_addr = '0;
    logic [7:0] cmd_nbytes = '0, tx_data = '0;
    logic [3:0] flag_clr = '0;
    logic [7:0] rx_data, fld_count;
    logic [9:0] fld_addr;
    logic       st_txis, st_rxne, st_tc, st_tcr, st_busy, st_stopf, st_nack, st_berr, st_arlo;
    logic       fld_ten, fld_rd, fld_reload, scl_hold, bit_req, bit_tx;
    logic [1:0] bit_op;
    logic       bit_done = 0, bit_rx = 0;

    int total = 0, bad = 0;

    always #2 clk = ~clk;

    i2cm_xfer_seq u_dut (.*);

    // ---- bit-level engine and target model ----
    bit   rq[$];
    bit   wlog[$];
    int   n_start = 0, n_stop = 0, n_wr = 0, arb_at = -1;
    logic [1:0] eng_cnt = '0;

    always @(posedge clk) begin
        bit_done <= 1'b0;
        if (!rst_n || !bit_req) eng_cnt <= '0;
        else if (!bit_done) begin
            if (eng_cnt == 2'd2) begin
                eng_cnt  <= '0;
                bit_done <= 1'b1;
                case (bit_op)
                    2'd0: begin n_start++; bit_rx <= 1'b1; end
                    2'd1: begin n_stop++;  bit_rx <= 1'b1; end
                    2'd2: begin
                        wlog.push_back(bit_tx);
                        bit_rx <= (n_wr == arb_at) ? 1'b0 : bit_tx;
                        n_wr++;
                    end
                    default: bit_rx <= (rq.size() > 0) ? rq.pop_front() : 1'b1;
                endcase
            end else eng_cnt <= eng_cnt + 1'b1;
        end
    end

    // ---- helpers ----
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit sig_val(input int w);
        case (w)
            0: return st_txis;
            1: return st_rxne;
            2: return st_tc;
            3: return st_tcr;
            4: return st_stopf;
            5: return st_nack;
            6: return st_arlo;
            default: return st_berr;
        endcase
    endfunction

    task automatic wait_sig(input int w, input string tag);
        bit found = 0;
        for (int i = 0; i < 3000; i++) begin
            if (sig_val(w)) begin found = 1; break; end
            @(negedge clk);
        end
        if (!found) chk(0, tag, 0, 1);
    endtask

    task automatic prep();
        rq.delete(); wlog.delete();
        n_start = 0; n_stop = 0; n_wr = 0; arb_at = -1;
    endtask

    task automatic pulse_start(input bit ten, input bit rd, input logic [9:0] a,
                               input logic [7:0] n, input bit rel);
        cmd_ten = ten; cmd_rd = rd; cmd_addr = a; cmd_nbytes = n; cmd_reload = rel;
        cmd_start = 1; @(negedge clk); cmd_start = 0;
    endtask

    task automatic pulse_count(input logic [7:0] n, input bit rel);
        cmd_nbytes = n; cmd_reload = rel;
        cmd_count_wr = 1; @(negedge clk); cmd_count_wr = 0;
    endtask

    task automatic pulse_stop();
        cmd_stop = 1; @(negedge clk); cmd_stop = 0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        tx_data = b; tx_wr = 1; @(negedge clk); tx_wr = 0;
    endtask

    task automatic read_byte(input logic [7:0] exp, input string tag);
        chk(rx_data == exp, tag, rx_data, exp);
        rx_rd = 1; @(negedge clk); rx_rd = 0;
    endtask

    task automatic clear_flags(input logic [3:0] v);
        flag_clr = v; @(negedge clk); flag_clr = '0;
    endtask

    task automatic push_bits(ref bit q[$], input logic [7:0] b);
        for (int i = 7; i >= 0; i--) q.push_back(b[i]);
    endtask

    task automatic cmp_log(ref bit exp[$], input string tag);
        bit ok = (exp.size() == wlog.size());
        if (ok) for (int i = 0; i < exp.size(); i++) if (exp[i] != wlog[i]) ok = 0;
        chk(ok, tag, wlog.size(), exp.size());
    endtask

    // full transfer, then STOP; data byte i = seed + i*0x1D
    task automatic run_xfer(input bit ten, input bit rd, input logic [9:0] a,
                            input logic [7:0] n, input logic [7:0] seed);
        bit exp[$];
        int nacks = ten ? (rd ? 3 : 2) : 1;
        prep();
        for (int k = 0; k < nacks; k++) rq.push_back(1'b0);
        if (ten) begin
            push_bits(exp, {5'b11110, a[9:8], 1'b0});
            push_bits(exp, a[7:0]);
            if (rd) push_bits(exp, {5'b11110, a[9:8], 1'b1});
        end else push_bits(exp, {a[7:1], rd});
        for (int b = 0; b < n; b++) begin
            logic [7:0] d = seed + 8'(b * 8'h1D);
            if (rd) begin push_bits(rq, d); exp.push_back(b == n - 1); end
            else begin push_bits(exp, d); rq.push_back(1'b0); end
        end
        pulse_start(ten, rd, a, n, 0);
        for (int b = 0; b < n; b++) begin
            logic [7:0] d = seed + 8'(b * 8'h1D);
            if (rd) begin wait_sig(1, "R5 rxne"); read_byte(d, "R5 rx byte"); end
            else begin wait_sig(0, "R4 txis"); chk(st_txis && !bit_req, "R4 stall", st_txis, 1); send_byte(d); end
        end
        wait_sig(2, "R6 tc");
        chk(!bit_req && scl_hold && n_stop == 0, "R6 held at tc", n_stop, 0);
        pulse_stop();
        wait_sig(4, "R6 stopf");
        chk(n_stop == 1, "R6 stop issued", n_stop, 1);
        chk(n_start == ((ten && rd) ? 2 : 1), "R3 start count", n_start, (ten && rd) ? 2 : 1);
        cmp_log(exp, ten ? "R3 bus bits" : "R2 bus bits");
        chk(fld_addr == 0 && fld_count == 0 && !fld_rd && !fld_ten && !fld_reload,
            "R12 fields cleared", fld_addr, 0);
        chk(!st_busy, "R11 busy low after stop", st_busy, 0);
        clear_flags(4'b0001);
    endtask

    localparam logic [27:0] VEC [7] = '{
        {1'b0, 1'b0, 10'h0A4, 8'd1, 8'h3C},
        {1'b0, 1'b0, 10'h15B, 8'd3, 8'hA5},
        {1'b0, 1'b1, 10'h0A4, 8'd1, 8'h5A},
        {1'b0, 1'b1, 10'h033, 8'd4, 8'h81},
        {1'b1, 1'b0, 10'h2F1, 8'd2, 8'h77},
        {1'b1, 1'b1, 10'h1C3, 8'd2, 8'hE4},
        {1'b0, 1'b0, 10'h07E, 8'd0, 8'h00}
    };

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk({st_txis, st_rxne, st_tc, st_tcr, st_busy, st_stopf, st_nack, st_berr, st_arlo} == 0,
            "R1 flags", st_busy, 0);
        chk(!bit_req && !scl_hold && fld_addr == 0 && fld_count == 0 && !fld_rd,
            "R1 bus and fields", bit_req, 0);

        foreach (VEC[i]) run_xfer(VEC[i][27], VEC[i][26], VEC[i][25:16], VEC[i][15:8], VEC[i][7:0]);

        // R7: reload write, 2 + 1 bytes
        prep();
        repeat (4) rq.push_back(1'b0);
        pulse_start(0, 0, 10'h064, 8'd2, 1);
        wait_sig(0, "R7 txis"); send_byte(8'h11);
        wait_sig(0, "R7 txis"); send_byte(8'h22);
        wait_sig(3, "R7 tcr");
        chk(!bit_req && scl_hold && fld_count == 0, "R7 held at tcr", bit_req, 0);
        repeat (20) @(negedge clk);
        chk(st_tcr && !bit_req && n_stop == 0, "R7 still stalled", n_stop, 0);
        pulse_count(8'd1, 0);
        wait_sig(0, "R7 txis after reload"); send_byte(8'h33);
        wait_sig(2, "R7 tc");
        chk(n_start == 1 && n_stop == 0, "R7 no start or stop", n_start, 1);
        pulse_stop(); wait_sig(4, "R7 stopf");
        chk(wlog.size() == 32, "R7 bit count", wlog.size(), 32);
        clear_flags(4'b0001);

        // R5: reload read, ack polarity at chunk end
        prep();
        rq.push_back(1'b0); push_bits(rq, 8'h9C); push_bits(rq, 8'h4B);
        pulse_start(0, 1, 10'h032, 8'd1, 1);
        wait_sig(1, "R5 rxne chunk1"); read_byte(8'h9C, "R5 rx chunk1");
        wait_sig(3, "R5 tcr");
        pulse_count(8'd1, 0);
        wait_sig(1, "R5 rxne chunk2"); read_byte(8'h4B, "R5 rx chunk2");
        wait_sig(2, "R5 tc");
        chk(wlog.size() == 10 && wlog[8] == 0 && wlog[9] == 1, "R5 ack then nack",
            (wlog.size() == 10) ? {wlog[8], wlog[9]} : 2'b11, 2'b01);
        pulse_stop(); wait_sig(4, "R5 stopf"); clear_flags(4'b0001);

        // R14: repeated start from tc wait
        prep();
        rq.push_back(1'b0); rq.push_back(1'b0);
        pulse_start(0, 0, 10'h0A2, 8'd1, 0);
        wait_sig(0, "R14 txis"); send_byte(8'h5E);
        wait_sig(2, "R14 tc");
        rq.push_back(1'b0); push_bits(rq, 8'hC6);
        pulse_start(0, 1, 10'h0A2, 8'd1, 0);
        wait_sig(1, "R14 rxne"); read_byte(8'hC6, "R14 rx after restart");
        wait_sig(2, "R14 tc2");
        chk(n_start == 2 && n_stop == 0, "R14 restart without stop", n_start, 2);
        pulse_stop(); wait_sig(4, "R14 stopf"); clear_flags(4'b0001);

        // R8: address NACK -> automatic STOP
        prep();
        rq.push_back(1'b1);
        pulse_start(0, 0, 10'h0F0, 8'd2, 0);
        wait_sig(5, "R8 nack");
        wait_sig(4, "R8 stopf");
        chk(st_nack && n_stop == 1 && !st_busy && !st_txis, "R8 auto stop", n_stop, 1);

        // R9: arbitration lost on third address bit
        prep();
        arb_at = 2;
        pulse_start(0, 0, 10'h0FE, 8'd1, 0);
        wait_sig(6, "R9 arlo");
        @(negedge clk);
        chk(!st_busy && !bit_req && n_stop == 0 && wlog.size() == 3, "R9 released", wlog.size(), 3);

        // R11 then R10: ignored start while busy, then bus error
        prep();
        rq.push_back(1'b0);
        pulse_start(0, 0, 10'h0C8, 8'd1, 0);
        wait_sig(0, "R11 txis");
        pulse_start(0, 1, 10'h055, 8'd3, 0);
        chk(fld_addr == 10'h0C8 && !fld_rd && st_txis && n_start == 1, "R11 start ignored", fld_addr, 10'h0C8);
        bus_err = 1; @(negedge clk); bus_err = 0;
        chk(st_berr && !st_busy && !st_txis && !bit_req, "R10 abort", st_busy, 0);

        // R13: w1c per flag
        chk(st_stopf && st_nack && st_berr && st_arlo, "R13 flags sticky", {st_stopf, st_nack, st_berr, st_arlo}, 4'hF);
        clear_flags(4'b0100);
        chk(!st_berr && st_arlo && st_nack && st_stopf, "R13 clear berr only",
            {st_arlo, st_berr, st_nack, st_stopf}, 4'b1011);
        clear_flags(4'b1011);
        chk(!st_arlo && !st_nack && !st_stopf && !st_berr, "R13 clear rest",
            {st_arlo, st_berr, st_nack, st_stopf}, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule